// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over software by counting down a 7-bit value on a slow, prescaled tick. Software must rewrite the counter at regular intervals. If it stops doing so, the counter falls out of its upper half and the block asks for a system reset. A refresh is also treated as a fault if it comes too soon, while the counter is still above a window value that software programs. Only a refresh made once the counter has dropped to or below that value is accepted.

Two byte-wide registers are reached through a plain write port and a combinational read port. The control register holds an enable flag and the live counter. The enable flag can be set but never cleared by software. The window register holds the threshold. A halt input and a clock-enable input both stop the prescaled time base. Every reset request is a single-cycle pulse that also puts all of the block's state back to its power-up values.

Top module: `window_watchdog`

## Requirements
- R1: `rd_sel`=0 returns the control register {enable flag in bit 7, counter in bits 6:0}, and `rd_sel`=1 returns the window register. The same encoding selects the target of a write through `wr_sel`.
- R2: In the window register, bit 7 always reads 0 and ignores writes, and bits 6:0 hold the window value.
- R3: After reset the control register reads 7Fh (disabled, counter 7Fh), the window reads 7Fh and `rst_req` is low.
- R4: Writing 1 to control bit 7 sets the enable flag. Writing 0 leaves it unchanged, and only a reset pulse or `rst_n` clears it.
- R5: While the enable flag is 0 and the write does not set it, no reset request is made, and a control write loads any counter value, including one with bit 6 clear.
- R6: Once enabled, the counter decrements by one every 16384 cycles in which `clk_en` is high and `halt` is low, counted from the edge that set the flag.
- R7: The prescaler and counter hold their values while `halt` is high or `clk_en` is low, and resume from the held values afterwards.
- R8: A decrement from 40h to 3Fh produces a reset request at that edge.
- R9: While enabled, a control write made when the counter is above the window value produces a reset request. A control write made when the counter is at or below the window value reloads the counter.
- R10: A control write that leaves the block enabled with counter bit 6 clear produces an immediate reset request.
- R11: `rst_req` is high for exactly one cycle. In that cycle the block already reads back its reset values, and writes presented during that cycle are discarded.
- R12: When a control write and a decrement fall on the same edge, the write wins. A legal refresh at the 40h-to-3Fh edge therefore prevents the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Prescaler advances only when high |
| halt | input | 1 | Freezes prescaler and counter when high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 window |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 window |
| rd_data | output | 8 | Read data for the selected register |
| rst_req | output | 1 | Single-cycle system reset request |

## Verification
The counter's scheduled decrement and a software refresh can arrive on the same clock edge. The sharpest case is the decrement that would take the counter from 40h to 3Fh and fire a reset. The bench counts edges from the enabling write and places a refresh with an in-window value exactly on the 32768th edge. It then judges that no reset pulse appears and that the control register reads back the refreshed value instead of 3Fh. The same edge counting checks the unrefreshed case, where the pulse must land on precisely that edge and on no other.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
   // Register select encoding shared by write and read ports
   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_WIN  = 1'b1
   } wwd_sel_e;
endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
   parameter int PRESC_W = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   generate
      if (PRESC_W == 0) begin : g_direct
         // No division: every running cycle is a tick
         assign tick = run;
      end else begin : g_divide
         logic [PRESC_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      div_q <= '0;
            else if (clr)    div_q <= '0;
            else if (run)    div_q <= div_q + 1'b1;
         end
         assign tick = run && (&div_q);
      end
   endgenerate
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   // Value whose decrement clears the top bit
   localparam logic [CNT_W-1:0] TRIP = CNT_W'(1) << (CNT_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '1;
      else if (clr)    cnt_q <= '1;
      else if (load)   cnt_q <= load_val;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
   end

   assign cnt    = cnt_q;
   assign expire = tick && !load && (cnt_q == TRIP);
endmodule

// File: rtl/wwd_window_cmp.sv
module wwd_window_cmp #(
   parameter int CNT_W = 7
) (
   input  logic             active,
   input  logic             wr_ctrl,
   input  logic [CNT_W:0]   wr_data,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] win,
   output logic             early,
   output logic             low_load
);
   logic enabled_after;

   always_comb begin
      enabled_after = active || wr_data[CNT_W];
      // Refresh while counter still above the window
      early         = wr_ctrl && active && (cnt > win);
      // Loading a value that is already past the trip point
      low_load      = wr_ctrl && enabled_after && !wr_data[CNT_W-1];
   end
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
   parameter int CNT_W   = 7,
   parameter int PRESC_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en,
   input  logic               halt,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [CNT_W:0]     wr_data,
   input  logic               rd_sel,
   output logic [CNT_W:0]     rd_data,
   output logic               rst_req
);
   import wwd_pkg::*;

   localparam int DATA_W = CNT_W + 1;

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("window_watchdog: CNT_W must be at least 3");
      end
      if (PRESC_W < 0 || PRESC_W > 24) begin : g_bad_presc
         $error("window_watchdog: PRESC_W out of range");
      end
   endgenerate

   logic             active_q;
   logic [CNT_W-1:0] win_q;
   logic [CNT_W-1:0] cnt;
   logic             rst_req_q;
   logic             wr_ok, wr_ctrl, wr_win;
   logic             tick, expire, early, low_load, fire, run;

   // Writes are discarded during the reset pulse cycle
   assign wr_ok   = wr_en && !rst_req_q;
   assign wr_ctrl = wr_ok && (wwd_sel_e'(wr_sel) == SEL_CTRL);
   assign wr_win  = wr_ok && (wwd_sel_e'(wr_sel) == SEL_WIN);
   assign run     = active_q && clk_en && !halt;
   assign fire    = early || low_load || expire;

   wwd_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (fire),
      .run  (run),
      .tick (tick)
   );

   wwd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fire),
      .load    (wr_ctrl),
      .load_val(wr_data[CNT_W-1:0]),
      .tick    (tick),
      .cnt     (cnt),
      .expire  (expire)
   );

   wwd_window_cmp #(.CNT_W(CNT_W)) u_cmp (
      .active  (active_q),
      .wr_ctrl (wr_ctrl),
      .wr_data (wr_data),
      .cnt     (cnt),
      .win     (win_q),
      .early   (early),
      .low_load(low_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         win_q     <= '1;
         rst_req_q <= 1'b0;
      end else if (fire) begin
         active_q  <= 1'b0;
         win_q     <= '1;
         rst_req_q <= 1'b1;
      end else begin
         rst_req_q <= 1'b0;
         if (wr_ctrl && wr_data[CNT_W]) active_q <= 1'b1;
         if (wr_win)                    win_q    <= wr_data[CNT_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (wwd_sel_e'(rd_sel))
         SEL_CTRL: rd_data = {active_q, cnt};
         SEL_WIN:  rd_data = DATA_W'({1'b0, win_q});
         default:  rd_data = '0;
      endcase
   end

   assign rst_req = rst_req_q;
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             halt,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [CNT_W:0]   wr_data,
   input logic             rd_sel,
   input logic [CNT_W:0]   rd_data,
   input logic             rst_req,
   input logic             active,
   input logic [CNT_W-1:0] cnt
);
   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_pulse_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!active && (&cnt)));

   assert_set_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> (active || rst_req));

   assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !(wr_en && !wr_sel && wr_data[CNT_W])) |=> !rst_req);

   assert_step_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (rst_req || (cnt == $past(cnt)) || (cnt == ($past(cnt) - CNT_W'(1)))));

   assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !wr_en) |=> (cnt == $past(cnt)));

   assert_win_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel |-> !rd_data[CNT_W]);
endmodule

bind window_watchdog wwd_checker #(.CNT_W(CNT_W)) u_wwd_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .halt   (halt),
   .wr_en  (wr_en),
   .wr_sel (wr_sel),
   .wr_data(wr_data),
   .rd_sel (rd_sel),
   .rd_data(rd_data),
   .rst_req(rst_req),
   .active (active_q),
   .cnt    (cnt)
);

// File: tb/window_watchdog_bench.sv
`timescale 1ns/1ps
module window_watchdog_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1;
   logic       halt = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic       rst_req;

   int unsigned cyc = 0;
   int unsigned c_last = 0;
   int          checks = 0;
   int          errors = 0;
   int unsigned exp_q[$];   // scoreboard: expected reset-pulse cycles

   localparam int unsigned TICK = 16384;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   window_watchdog u_window_watchdog (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .halt(halt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req)
   );

   // Monitor: every pulse must match the front of the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && rst_req) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8/R9/R10/R5 unexpected rst_req at cycle %0d (expected none)", cyc);
         end else begin
            int unsigned e;
            e = exp_q.pop_front();
            if (e != cyc) begin
               errors++;
               $display("FAIL R8/R9/R10 rst_req at cycle %0d, expected %0d", cyc, e);
            end
         end
      end
   end

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      c_last = cyc;
   endtask

   task automatic rd_check(input logic sel, input logic [7:0] exp, input string tag);
      rd_sel = sel;
      #0.2;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s read sel=%0d actual %h expected %h", tag, sel, rd_data, exp);
      end
   endtask

   task automatic wait_cyc(input int unsigned n);
      while (cyc != n) @(negedge clk);
   endtask

   task automatic finish_run();
      while (exp_q.size() != 0) begin
         int unsigned e;
         e = exp_q.pop_front();
         checks++; errors++;
         $display("FAIL R8/R9/R10 missing rst_req, actual none expected cycle %0d", e);
      end
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired, actual cycle %0d expected completion", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      rd_check(1'b0, 8'h7F, "R3");
      rd_check(1'b1, 8'h7F, "R3");
      checks++;
      if (rst_req !== 1'b0) begin errors++; $display("FAIL R3 rst_req actual %b expected 0", rst_req); end

      // R2 window msb ignored, R1 window read-back
      wr(1'b1, 8'hFF);
      @(negedge clk); rd_check(1'b1, 8'h7F, "R2");
      wr(1'b1, 8'h50);
      @(negedge clk); rd_check(1'b1, 8'h50, "R1");

      // R5 disabled: low value loads freely, no pulse; R4 flag stays 0
      wr(1'b0, 8'h00);
      @(negedge clk); rd_check(1'b0, 8'h00, "R5");
      wr(1'b0, 8'h7F);
      @(negedge clk); rd_check(1'b0, 8'h7F, "R1");

      // R6/R8 rollover timing from enabling write; R4 set-only
      wr(1'b0, 8'hC1);
      c0 = c_last;
      exp_q.push_back(c0 + 2*TICK);
      wr(1'b0, 8'h41);   // bit7=0, 41h <= 50h legal refresh
      @(negedge clk); rd_check(1'b0, 8'hC1, "R4");
      wait_cyc(c0 + TICK - 1); rd_check(1'b0, 8'hC1, "R6");
      wait_cyc(c0 + TICK);     rd_check(1'b0, 8'hC0, "R6");
      wait_cyc(c0 + 2*TICK + 1);
      rd_check(1'b0, 8'h7F, "R11");
      rd_check(1'b1, 8'h7F, "R11");

      // R9 early refresh above window, R11 write in pulse cycle discarded
      wr(1'b1, 8'h50);
      wr(1'b0, 8'hFF);
      wr(1'b0, 8'h7F);
      exp_q.push_back(c_last);
      wr(1'b1, 8'h22);
      @(negedge clk); rd_check(1'b1, 8'h7F, "R11");
      rd_check(1'b0, 8'h7F, "R9");

      // R9 legal refresh, R10 low load while enabled
      wr(1'b0, 8'hC8);
      wr(1'b0, 8'h7F);
      @(negedge clk); rd_check(1'b0, 8'hFF, "R9");
      wr(1'b0, 8'h3F);
      exp_q.push_back(c_last);
      @(negedge clk); @(negedge clk);
      rd_check(1'b0, 8'h7F, "R10");

      // R7 halt and clock-enable freeze
      wr(1'b0, 8'hC1);
      c0 = c_last;
      wait_cyc(c0 + 100);
      halt = 1'b1;
      wait_cyc(c0 + 1100);
      rd_check(1'b0, 8'hC1, "R7");
      halt = 1'b0;
      wait_cyc(c0 + 2000);
      clk_en = 1'b0;
      wait_cyc(c0 + 2500);
      clk_en = 1'b1;
      exp_q.push_back(c0 + 2*TICK + 1500);
      wait_cyc(c0 + TICK + 1499); rd_check(1'b0, 8'hC1, "R7");
      wait_cyc(c0 + TICK + 1500); rd_check(1'b0, 8'hC0, "R7");
      wait_cyc(c0 + 2*TICK + 1502);
      rd_check(1'b0, 8'h7F, "R8");

      // R12 refresh on the same edge as the 40h->3Fh decrement
      wr(1'b0, 8'hC1);
      c0 = c_last;
      wait_cyc(c0 + 2*TICK - 1);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h7F;
      @(posedge clk); #1;
      wr_en = 1'b0;
      @(negedge clk); rd_check(1'b0, 8'hFF, "R12");
      repeat (20) @(negedge clk);
      rd_check(1'b0, 8'hFF, "R12");

      finish_run();
   end
endmodule